// File: doc/BRIEF.md
# Serial Flash Controller Host FIFO and Interrupt Front-End

This block is the host-facing register side of a serial flash controller. The host reaches it through a plain strobe interface with one write strobe, one read strobe and a 3-bit word index. A single data register feeds a 32-bit transmit FIFO on writes and drains a 32-bit receive FIFO on reads. On the other side, the flash shifter pops transmit words and pushes receive words through a simple port.

A status word reports the level and the full and empty flags of each FIFO. An eight-source raw interrupt register collects FIFO events and four external event pulses. Bits are cleared by writing ones to a clear register, and a mask register selects which raw bits drive the interrupt line. If the host writes while the transmit FIFO is full, or reads while the receive FIFO is empty, the matching interrupt bit is set. The access is never lost without trace.

Writing bit 0 of a recovery register starts a soft reset that lasts a fixed number of cycles. The bit reads back as 1 while the reset is in progress. During that time both FIFOs are emptied and the raw interrupt bits are cleared.

Top module: `sfc_fifo_front`

## Requirements
- R1: After the reset input is released, the status word reads 0x0000_0006 (both FIFOs empty), the raw register reads 0, the mask register reads 0 and irq is low.
- R2: The register index map is: 0 mask, 1 clear, 2 raw, 3 status, 4 recovery, 5 data. A write to index 5 pushes the word into the TX FIFO. The shifter pops words in write order, and sh_tx_data shows the head word. Status bits 12:8 hold the TX level and bit 1 is TX empty.
- R3: The TX FIFO holds 16 words, and status bit 0 shows TX full. A data write while the FIFO is full is dropped and sets raw bit 2.
- R4: A read of index 5 pops the RX FIFO in push order, and reg_rdata carries the word one cycle after the read strobe. Status bits 20:16 hold the RX level and bit 2 is RX empty. A read while the RX FIFO is empty returns 0 and sets raw bit 1.
- R5: A shifter pop that empties the TX FIFO sets raw bit 3. A shifter push that fills the RX FIFO sets raw bit 0, and status bit 3 shows RX full.
- R6: One-cycle pulses set raw bits as follows: ev_xfer_done sets bit 4, ev_bus_err sets bit 5, ev_serial_err sets bit 6 and ev_dma_done sets bit 7.
- R7: Writing index 1 clears exactly the raw bits written as 1, so writing all ones clears every bit. If a bit is set and cleared in the same cycle, the set wins. Index 1 reads as 0.
- R8: irq is high exactly when some raw bit is 1 and its mask bit is 1. The mask is at index 0, bits 7:0.
- R9: Writing 1 to bit 0 of index 4 starts a soft reset lasting RST_CYCLES cycles, during which that bit reads 1. After the reset both FIFOs are empty and the raw register is 0. The mask register is kept.
- R10: A shifter pop from an empty TX FIFO sees data 0 and sets no raw bit. A shifter push into a full RX FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Masked interrupt request |
| sh_tx_pop | input | 1 | Shifter takes the TX head word |
| sh_tx_data | output | 32 | TX head word, 0 when empty |
| sh_rx_push | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | 32 | Received word |
| ev_xfer_done | input | 1 | Transfer finished pulse |
| ev_bus_err | input | 1 | System bus error pulse |
| ev_serial_err | input | 1 | Serial link error pulse |
| ev_dma_done | input | 1 | DMA finished pulse |

## Verification
The hardest case to reach is a raw bit being set and cleared in the same cycle. An event pulse has to be aligned with a clear-register write on a single edge, and the bench does this by driving both from one task at the same falling edge. A second hard case is the FIFO boundary behaviour: an access dropped when full and another made when empty. Here the stimulus fills each FIFO to exactly sixteen words before the extra access. It then drains the FIFO completely, which proves that the dropped word never entered and that the draining pop raises the empty or full event.

// File: rtl/sfc_fe_pkg.sv
// Shared constants for the flash controller front-end: register indices,
// interrupt bit positions and status word field positions.
package sfc_fe_pkg;
    localparam int REG_W  = 32;
    localparam int NIRQ   = 8;

    typedef enum logic [2:0] {
        RA_MASK    = 3'd0,
        RA_CLEAR   = 3'd1,
        RA_RAW     = 3'd2,
        RA_STATUS  = 3'd3,
        RA_RECOVER = 3'd4,
        RA_DATA    = 3'd5
    } reg_idx_e;

    // raw interrupt bit positions
    localparam int IRQ_RXFULL   = 0;
    localparam int IRQ_RXUNDER  = 1;
    localparam int IRQ_TXOVER   = 2;
    localparam int IRQ_TXEMPTY  = 3;
    localparam int IRQ_XFERDONE = 4;
    localparam int IRQ_BUSERR   = 5;
    localparam int IRQ_SERERR   = 6;
    localparam int IRQ_DMADONE  = 7;

    // status word positions
    localparam int ST_TXFULL  = 0;
    localparam int ST_TXEMPTY = 1;
    localparam int ST_RXEMPTY = 2;
    localparam int ST_RXFULL  = 3;
    localparam int ST_TXLVL   = 8;
    localparam int ST_RXLVL   = 16;
    localparam int ST_LVL_W   = 5;
endpackage

// File: rtl/word_fifo.sv
// Synchronous FIFO of W-bit words.
// Assumes DEPTH is a power of two. A push while full and a pop while empty
// are ignored. head reads 0 when empty. flush empties the FIFO in one cycle.
module word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign level   = cnt;
    assign head    = empty ? '0 : mem[rptr];

    // storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wptr] <= push_data;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LW'(DEPTH));
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/irq_bank.sv
// Raw interrupt register with write-one-to-clear and a mask.
// Assumes set and clear vectors are single-cycle strobes; set wins over clear.
module irq_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] raw, mask;

    // raw bits: flush clears, then clear-by-one, then set has priority
    always_ff @(posedge clk) begin
        if (!rst_n || flush) raw <= '0;
        else                 raw <= (raw & ~clr_i) | set_i;
    end

    // mask register, kept across soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    assign raw_o  = raw;
    assign mask_o = mask;
    assign irq_o  = |(raw & mask);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && set_i != '0) |=> ((raw & $past(set_i)) == $past(set_i)));
    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((raw & $past(clr_i & ~set_i)) == '0));
    a_r8_no_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);
endmodule

// File: rtl/soft_rst_seq.sv
// Self-clearing soft reset sequencer: busy is high for CYCLES cycles after start.
// Assumes start is ignored while busy.
module soft_rst_seq #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES) + 1;
    logic [CW-1:0] cnt;

    // count down the reset window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= CW'(CYCLES - 1);
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    a_r9_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/sfc_fifo_front.sv
// Host register front-end of a serial flash controller: TX/RX word FIFOs behind
// one data register, status word, raw/mask/clear interrupts and soft reset.
// Assumes one register access per cycle; read data appears one cycle after reg_rd.
module sfc_fifo_front
    import sfc_fe_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    input  logic             sh_tx_pop,
    output logic [REG_W-1:0] sh_tx_data,
    input  logic             sh_rx_push,
    input  logic [REG_W-1:0] sh_rx_data,
    input  logic             ev_xfer_done,
    input  logic             ev_bus_err,
    input  logic             ev_serial_err,
    input  logic             ev_dma_done
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic             busy, rst_start;
    logic             wr_data, rd_data;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [REG_W-1:0] rx_head;
    logic [NIRQ-1:0]  irq_set, irq_clr, raw, mask;
    logic [REG_W-1:0] status;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:NIRQ];

    assign wr_data   = reg_wr && (reg_addr == RA_DATA) && !busy;
    assign rd_data   = reg_rd && (reg_addr == RA_DATA) && !busy;
    assign rst_start = reg_wr && (reg_addr == RA_RECOVER) && reg_wdata[0];

    soft_rst_seq #(.CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .start(rst_start), .busy(busy)
    );

    word_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(busy),
        .push(wr_data), .push_data(reg_wdata), .pop(sh_tx_pop),
        .head(sh_tx_data), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    word_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(busy),
        .push(sh_rx_push), .push_data(sh_rx_data), .pop(rd_data),
        .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    // interrupt event sources
    always_comb begin
        irq_set               = '0;
        irq_set[IRQ_RXFULL]   = sh_rx_push && (rx_level == LVL_W'(FIFO_DEPTH - 1))
                                && !(rd_data && !rx_empty);
        irq_set[IRQ_RXUNDER]  = rd_data && rx_empty;
        irq_set[IRQ_TXOVER]   = wr_data && tx_full;
        irq_set[IRQ_TXEMPTY]  = sh_tx_pop && (tx_level == LVL_W'(1)) && !wr_data;
        irq_set[IRQ_XFERDONE] = ev_xfer_done;
        irq_set[IRQ_BUSERR]   = ev_bus_err;
        irq_set[IRQ_SERERR]   = ev_serial_err;
        irq_set[IRQ_DMADONE]  = ev_dma_done;
    end

    assign irq_clr = (reg_wr && reg_addr == RA_CLEAR) ? reg_wdata[NIRQ-1:0] : '0;

    irq_bank #(.N(NIRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .flush(busy),
        .set_i(irq_set), .clr_i(irq_clr),
        .mask_we(reg_wr && reg_addr == RA_MASK), .mask_wdata(reg_wdata[NIRQ-1:0]),
        .raw_o(raw), .mask_o(mask), .irq_o(irq)
    );

    // pack FIFO levels and flags into the status word
    always_comb begin
        status                               = '0;
        status[ST_TXFULL]                    = tx_full;
        status[ST_TXEMPTY]                   = tx_empty;
        status[ST_RXEMPTY]                   = rx_empty;
        status[ST_RXFULL]                    = rx_full;
        status[ST_TXLVL +: ST_LVL_W]         = ST_LVL_W'(tx_level);
        status[ST_RXLVL +: ST_LVL_W]         = ST_LVL_W'(rx_level);
    end

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                RA_MASK:    reg_rdata <= REG_W'(mask);
                RA_RAW:     reg_rdata <= REG_W'(raw);
                RA_STATUS:  reg_rdata <= status;
                RA_RECOVER: reg_rdata <= REG_W'(busy);
                RA_DATA:    reg_rdata <= busy ? '0 : rx_head;
                default:    reg_rdata <= '0;
            endcase
        end
    end

    a_r3_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full) |=> raw[IRQ_TXOVER]);
    a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_empty) |=> (raw[IRQ_RXUNDER] && reg_rdata == '0));
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (tx_empty && rx_empty));
    a_r9_flush_raw: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (raw == '0));
endmodule

// File: tb/sim_sfc_fifo_front.sv
module sim_sfc_fifo_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        sh_tx_pop = 1'b0;
    logic [31:0] sh_tx_data;
    logic        sh_rx_push = 1'b0;
    logic [31:0] sh_rx_data = '0;
    logic        ev_xfer_done = 1'b0, ev_bus_err = 1'b0;
    logic        ev_serial_err = 1'b0, ev_dma_done = 1'b0;

    int nchk = 0;
    int nerr = 0;

    localparam logic [2:0] A_MASK = 3'd0, A_CLR = 3'd1, A_RAW = 3'd2,
                           A_STAT = 3'd3, A_REC = 3'd4, A_DATA = 3'd5;

    always #4 clk = ~clk;

    sfc_fifo_front #(.FIFO_DEPTH(16), .RST_CYCLES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
        .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
        .ev_xfer_done(ev_xfer_done), .ev_bus_err(ev_bus_err),
        .ev_serial_err(ev_serial_err), .ev_dma_done(ev_dma_done)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all helpers start and end at a falling edge
    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic sh_pop(output logic [31:0] d);
        d = sh_tx_data;
        sh_tx_pop = 1'b1;
        @(negedge clk);
        sh_tx_pop = 1'b0;
    endtask

    task automatic sh_push(logic [31:0] d);
        sh_rx_push = 1'b1; sh_rx_data = d;
        @(negedge clk);
        sh_rx_push = 1'b0;
    endtask

    task automatic chk_reg(string tag, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        chk_reg("R1 status", A_STAT, 32'h0000_0006);
        chk_reg("R1 raw", A_RAW, 32'h0);
        chk_reg("R1 mask", A_MASK, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_tx_path;
        logic [31:0] v;
        wr(A_DATA, 32'hA1A1_0001);
        wr(A_DATA, 32'hB2B2_0002);
        wr(A_DATA, 32'hC3C3_0003);
        chk_reg("R2 status tx level 3", A_STAT, 32'h0000_0304);
        sh_pop(v); chk("R2 pop order 0", v, 32'hA1A1_0001);
        sh_pop(v); chk("R2 pop order 1", v, 32'hB2B2_0002);
        chk_reg("R5 raw before drain", A_RAW, 32'h0);
        sh_pop(v); chk("R2 pop order 2", v, 32'hC3C3_0003);
        chk_reg("R5 tx drained sets bit3", A_RAW, 32'h0000_0008);
        chk_reg("R2 status empty again", A_STAT, 32'h0000_0006);
        chk_reg("R7 clear reads zero", A_CLR, 32'h0);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk_reg("R7 all ones clears", A_RAW, 32'h0);
    endtask

    task automatic t_tx_overflow;
        logic [31:0] v;
        for (int i = 0; i < 16; i++) wr(A_DATA, 32'h1000_0000 + i);
        chk_reg("R3 status full", A_STAT, 32'h0000_1005);
        chk_reg("R3 no overflow yet", A_RAW, 32'h0);
        wr(A_DATA, 32'hDEAD_BEEF);
        chk_reg("R3 overflow bit2", A_RAW, 32'h0000_0004);
        chk_reg("R3 level still 16", A_STAT, 32'h0000_1005);
        for (int i = 0; i < 16; i++) begin
            sh_pop(v);
            chk("R3 drain order", v, 32'h1000_0000 + i);
        end
        chk_reg("R3 dropped word absent", {29'b0, A_STAT}, 32'h0000_0006);
        chk_reg("R5 drain after overflow", A_RAW, 32'h0000_000C);
        wr(A_CLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_rx_path;
        logic [31:0] v;
        sh_push(32'h5555_0001);
        sh_push(32'h6666_0002);
        sh_push(32'h7777_0003);
        chk_reg("R4 status rx level 3", A_STAT, 32'h0003_0002);
        rd(A_DATA, v); chk("R4 read order 0", v, 32'h5555_0001);
        rd(A_DATA, v); chk("R4 read order 1", v, 32'h6666_0002);
        rd(A_DATA, v); chk("R4 read order 2", v, 32'h7777_0003);
        chk_reg("R4 no underflow yet", A_RAW, 32'h0);
        rd(A_DATA, v); chk("R4 empty read zero", v, 32'h0);
        chk_reg("R4 underflow bit1", A_RAW, 32'h0000_0002);
        wr(A_CLR, 32'h0000_0002);
        chk_reg("R7 single clear", A_RAW, 32'h0);
    endtask

    task automatic t_rx_full;
        logic [31:0] v;
        for (int i = 0; i < 15; i++) sh_push(32'h2000_0000 + i);
        chk_reg("R5 rx not full at 15", A_RAW, 32'h0);
        sh_push(32'h2000_000F);
        chk_reg("R5 rx full bit0", A_RAW, 32'h0000_0001);
        chk_reg("R5 status rx full", A_STAT, 32'h0010_000A);
        sh_push(32'hBAD0_BAD0);
        chk_reg("R10 push on full dropped", A_STAT, 32'h0010_000A);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v);
            chk("R10 rx order after drop", v, 32'h2000_0000 + i);
        end
        chk_reg("R10 rx empty after drain", A_STAT, 32'h0000_0006);
        wr(A_CLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_events;
        ev_xfer_done = 1'b1; @(negedge clk); ev_xfer_done = 1'b0;
        chk_reg("R6 xfer done bit4", A_RAW, 32'h10);
        ev_bus_err = 1'b1; @(negedge clk); ev_bus_err = 1'b0;
        chk_reg("R6 bus err bit5", A_RAW, 32'h30);
        ev_serial_err = 1'b1; @(negedge clk); ev_serial_err = 1'b0;
        chk_reg("R6 serial err bit6", A_RAW, 32'h70);
        ev_dma_done = 1'b1; @(negedge clk); ev_dma_done = 1'b0;
        chk_reg("R6 dma done bit7", A_RAW, 32'hF0);
    endtask

    task automatic t_clear;
        wr(A_CLR, 32'h0000_0030);
        chk_reg("R7 partial clear", A_RAW, 32'hC0);
        ev_bus_err = 1'b1;
        wr(A_CLR, 32'h0000_0020);
        ev_bus_err = 1'b0;
        chk_reg("R7 set wins over clear", A_RAW, 32'hE0);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk_reg("R7 clear all", A_RAW, 32'h0);
    endtask

    task automatic t_irq;
        wr(A_MASK, 32'h10);
        chk_reg("R8 mask readback", A_MASK, 32'h10);
        chk("R8 no raw no irq", {31'b0, irq}, 32'h0);
        ev_xfer_done = 1'b1; @(negedge clk); ev_xfer_done = 1'b0;
        chk("R8 enabled source irq", {31'b0, irq}, 32'h1);
        wr(A_MASK, 32'h01);
        chk("R8 masked source quiet", {31'b0, irq}, 32'h0);
        wr(A_CLR, 32'hFFFF_FFFF);
        ev_bus_err = 1'b1; @(negedge clk); ev_bus_err = 1'b0;
        chk("R8 other source masked", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h20);
        chk("R8 mask enables later", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk("R8 clear drops irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_soft_reset;
        wr(A_MASK, 32'h80);
        wr(A_DATA, 32'h1111_1111);
        wr(A_DATA, 32'h2222_2222);
        sh_push(32'h3333_3333);
        ev_dma_done = 1'b1; @(negedge clk); ev_dma_done = 1'b0;
        chk("R9 irq before reset", {31'b0, irq}, 32'h1);
        wr(A_REC, 32'h1);
        chk_reg("R9 busy reads one", A_REC, 32'h1);
        repeat (6) @(negedge clk);
        chk_reg("R9 busy self clears", A_REC, 32'h0);
        chk_reg("R9 fifos emptied", A_STAT, 32'h0000_0006);
        chk_reg("R9 raw cleared", A_RAW, 32'h0);
        chk_reg("R9 mask kept", A_MASK, 32'h80);
        chk("R9 irq low after reset", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h0);
    endtask

    task automatic t_shifter_misuse;
        logic [31:0] v;
        sh_pop(v);
        chk("R10 empty tx data zero", v, 32'h0);
        chk_reg("R10 empty pop no flag", A_RAW, 32'h0);
        chk_reg("R10 empty pop no level change", A_STAT, 32'h0000_0006);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_path();
        t_tx_overflow();
        t_rx_path();
        t_rx_full();
        t_events();
        t_clear();
        t_irq();
        t_soft_reset();
        t_shifter_misuse();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule